// File: doc/BRIEF.md
# Index-Base-Displacement Address Generator

This block turns a memory operand into an effective byte address. The operand has three parts: a 4-bit index field, a 4-bit base field and a 12-bit displacement. Each register field names one of sixteen 16-bit general registers. The block reads those registers through two external read ports. A field value of zero means "no register", so that term adds nothing and the block does not read its port. The selected register values and the zero-extended displacement are added modulo 2^16 to give a 16-bit logical address.

A mode input limits the operand to base plus displacement, which removes the index term. An access-size input tells the block whether the access is a byte or a halfword. From that size the block drives a two-bit byte-lane select. It also decides whether the access is misaligned. The address and the lane select are combinational. A strobe input captures a registered valid/fault pair at the next clock edge, and the downstream pipeline uses that pair to raise an alignment fault.

Top module: `ibd_addr_gen`

## Requirements
- R1: `eff_addr` equals the index term plus the base term plus the zero-extended displacement, taken modulo 2^16. A sum of 2^16 or more wraps.
- R2: When `op_index` is 0, the index term is zero and `idx_rd_en` is low. The value on `idx_rd_data` has no effect on `eff_addr`.
- R3: When `op_base` is 0, the base term is zero and `base_rd_en` is low. The value on `base_rd_data` has no effect on `eff_addr`.
- R4: When `bd_only` is 1, the index term is zero and `idx_rd_en` is low, whatever the value of `op_index`.
- R5: `idx_rd_sel` always equals `op_index`, and `base_rd_sel` always equals `op_base`.
- R6: `lane_sel` is 2'b11 for a halfword access (`is_half`=1). For a byte access it is 2'b01 when `eff_addr[0]` is 0 and 2'b10 when `eff_addr[0]` is 1.
- R7: After each rising clock edge with `strobe`=1, `res_valid` is 1 and `res_fault` equals `is_half` AND `eff_addr[0]` as sampled at that edge. After an edge with `strobe`=0, both outputs are 0.
- R8: A byte access never sets `res_fault`, whether its address is odd or even.
- R9: While `rst_n` is low, and after reset is released until the first strobe, `res_valid` and `res_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_index | input | 4 | Index register field (0 = none) |
| op_base | input | 4 | Base register field (0 = none) |
| op_disp | input | 12 | Unsigned displacement |
| bd_only | input | 1 | 1 = base plus displacement only; the index term is dropped |
| is_half | input | 1 | 1 = halfword access, 0 = byte access |
| strobe | input | 1 | Capture the valid/fault pair at this edge |
| idx_rd_sel | output | 4 | Register number for the index read port |
| idx_rd_en | output | 1 | Index read port enable |
| idx_rd_data | input | 16 | Index read port data |
| base_rd_sel | output | 4 | Register number for the base read port |
| base_rd_en | output | 1 | Base read port enable |
| base_rd_data | input | 16 | Base read port data |
| eff_addr | output | 16 | Effective byte address |
| lane_sel | output | 2 | Byte-lane select (bit 0 = even byte, bit 1 = odd byte) |
| res_valid | output | 1 | Registered: a strobe was captured at the last edge |
| res_fault | output | 1 | Registered: the captured access was a misaligned halfword |

## Verification
Random operands with random register contents exercise the full three-term sum. Register values near 16'hFFFF force carries and wraparound, which separate correct modulo arithmetic from a truncated or sign-extended displacement. Directed operands put zero in each field while register 0 holds a non-zero marker, so a design that reads register 0 instead of suppressing the term gives a different address. The same marker with `bd_only` set shows whether the mode drops the index term. Odd and even addresses, each with both access sizes and with strobe on and off, show whether the fault depends on the size and whether the registered pair follows the strobe.

// File: rtl/ibd_pkg.sv
package ibd_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned DISP_W  = 12;
  localparam int unsigned LANES   = 2;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [DISP_W-1:0]  disp_t;
  typedef logic [LANES-1:0]   lane_t;

  // zero-extend the displacement to address width
  function automatic addr_t widen_disp(input disp_t d);
    return addr_t'(d);
  endfunction

  // modulo-2^ADDR_W sum of three terms
  function automatic addr_t sum3(input addr_t a, input addr_t b, input addr_t c);
    return a + b + c;
  endfunction

  // halfword enables both lanes; a byte picks the lane named by bit 0
  function automatic lane_t pick_lanes(input logic half, input logic odd);
    lane_t l;
    if (half) l = '1;
    else      l = odd ? lane_t'(2'b10) : lane_t'(2'b01);
    return l;
  endfunction
endpackage

// File: rtl/ibd_reg_term.sv
module ibd_reg_term
  import ibd_pkg::*;
#(
  parameter int unsigned W  = ADDR_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] fld,
  input  logic          allow,
  output logic [FW-1:0] rd_sel,
  output logic          rd_en,
  input  logic [W-1:0]  rd_data,
  output logic [W-1:0]  term
);
  logic fld_is_zero;

  assign fld_is_zero = (fld == '0);
  assign rd_sel      = fld;
  assign rd_en       = allow && !fld_is_zero;
  assign term        = rd_en ? rd_data : '0;

  // R2 R3
  zero_field_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_is_zero |-> (!rd_en && term == '0));

  // R4
  blocked_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |-> (!rd_en && term == '0));
endmodule

// File: rtl/ibd_access_check.sv
module ibd_access_check
  import ibd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr,
  input  logic  half,
  input  logic  strobe,
  output lane_t lanes,
  output logic  valid_q,
  output logic  fault_q
);
  logic misaligned;

  assign misaligned = half && addr[0];
  assign lanes      = pick_lanes(half, addr[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= strobe;
      fault_q <= strobe && misaligned;
    end
  end

  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half |-> ($countones(lanes) == 1));

  // R7
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> valid_q);

  // R7
  fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> valid_q);

  // R8
  byte_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !half) |=> !fault_q);
endmodule

// File: rtl/ibd_addr_gen.sv
module ibd_addr_gen
  import ibd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op_index,
  input  logic [3:0]  op_base,
  input  logic [11:0] op_disp,
  input  logic        bd_only,
  input  logic        is_half,
  input  logic        strobe,
  output logic [3:0]  idx_rd_sel,
  output logic        idx_rd_en,
  input  logic [15:0] idx_rd_data,
  output logic [3:0]  base_rd_sel,
  output logic        base_rd_en,
  input  logic [15:0] base_rd_data,
  output logic [15:0] eff_addr,
  output logic [1:0]  lane_sel,
  output logic        res_valid,
  output logic        res_fault
);
  addr_t idx_term, base_term, disp_term;

  ibd_reg_term u_idx (
    .clk(clk), .rst_n(rst_n), .fld(op_index), .allow(!bd_only),
    .rd_sel(idx_rd_sel), .rd_en(idx_rd_en), .rd_data(idx_rd_data),
    .term(idx_term)
  );

  ibd_reg_term u_base (
    .clk(clk), .rst_n(rst_n), .fld(op_base), .allow(1'b1),
    .rd_sel(base_rd_sel), .rd_en(base_rd_en), .rd_data(base_rd_data),
    .term(base_term)
  );

  assign disp_term = widen_disp(op_disp);
  assign eff_addr  = sum3(idx_term, base_term, disp_term);

  ibd_access_check u_chk (
    .clk(clk), .rst_n(rst_n), .addr(eff_addr), .half(is_half),
    .strobe(strobe), .lanes(lane_sel), .valid_q(res_valid),
    .fault_q(res_fault)
  );

  // R4
  mode_drops_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bd_only |-> !idx_rd_en);

  // R1
  no_regs_is_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_rd_en && !base_rd_en) |-> (eff_addr == {4'h0, op_disp}));
endmodule

// File: tb/ibd_addr_gen_tb.sv
module ibd_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_index = '0, op_base = '0;
  logic [11:0] op_disp = '0;
  logic        bd_only = 1'b0, is_half = 1'b0, strobe = 1'b0;
  logic [3:0]  idx_rd_sel, base_rd_sel;
  logic        idx_rd_en, base_rd_en;
  logic [15:0] idx_rd_data, base_rd_data, eff_addr;
  logic [1:0]  lane_sel;
  logic        res_valid, res_fault;
  logic [15:0] regs [16];

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign idx_rd_data  = regs[idx_rd_sel];
  assign base_rd_data = regs[base_rd_sel];

  ibd_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .op_index(op_index), .op_base(op_base),
    .op_disp(op_disp), .bd_only(bd_only), .is_half(is_half), .strobe(strobe),
    .idx_rd_sel(idx_rd_sel), .idx_rd_en(idx_rd_en), .idx_rd_data(idx_rd_data),
    .base_rd_sel(base_rd_sel), .base_rd_en(base_rd_en),
    .base_rd_data(base_rd_data), .eff_addr(eff_addr), .lane_sel(lane_sel),
    .res_valid(res_valid), .res_fault(res_fault)
  );

  function automatic logic [15:0] want_addr(input logic [3:0] x, input logic [3:0] b,
                                            input logic [11:0] d, input logic bdo);
    logic [16:0] acc;
    acc = {5'd0, d};
    if (x != 0 && !bdo) acc = acc + {1'b0, regs[x]};
    if (b != 0)         acc = acc + {1'b0, regs[b]};
    return acc[15:0];
  endfunction

  function automatic logic [1:0] want_lane(input logic half, input logic [15:0] a);
    if (half) return 2'b11;
    return a[0] ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] x, input logic [3:0] b, input logic [11:0] d,
                       input logic bdo, input logic half, input logic stb);
    logic [15:0] ea;
    @(negedge clk);
    op_index = x; op_base = b; op_disp = d; bd_only = bdo; is_half = half; strobe = stb;
    #1;
    ea = want_addr(x, b, d, bdo);
    check("R1", eff_addr, ea);
    check("R2_R4_idx_en", idx_rd_en, (x != 0) && !bdo);
    check("R3_base_en", base_rd_en, b != 0);
    check("R5", {idx_rd_sel, base_rd_sel}, {x, b});
    check("R6", lane_sel, want_lane(half, ea));
    @(posedge clk); #1;
    check("R7_valid", res_valid, stb);
    check("R7_R8_fault", res_fault, stb && half && ea[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) regs[i] = 16'(i * 16'h1111 + 16'h0101);
    regs[0] = 16'hBEEF;  // marker: must never enter the sum
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9_valid", res_valid, 1'b0);
    check("R9_fault", res_fault, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9_after", {res_valid, res_fault}, 2'b00);

    // R2 zero index, R3 zero base, both zero
    apply(4'd0, 4'd5, 12'h123, 1'b0, 1'b0, 1'b1);
    apply(4'd7, 4'd0, 12'h456, 1'b0, 1'b1, 1'b1);
    apply(4'd0, 4'd0, 12'hFFF, 1'b0, 1'b0, 1'b1);
    // R4 base-displacement mode drops index
    apply(4'd9, 4'd3, 12'h010, 1'b1, 1'b1, 1'b1);
    // R1 wraparound
    regs[14] = 16'hFFFF; regs[15] = 16'hFFFE;
    apply(4'd14, 4'd15, 12'hFFF, 1'b0, 1'b0, 1'b1);
    // R7 R8 odd halfword faults, odd byte does not, no strobe no result
    regs[2] = 16'h0001;
    apply(4'd0, 4'd2, 12'h000, 1'b0, 1'b1, 1'b1);
    apply(4'd0, 4'd2, 12'h000, 1'b0, 1'b0, 1'b1);
    apply(4'd0, 4'd2, 12'h000, 1'b0, 1'b1, 1'b0);
    apply(4'd0, 4'd2, 12'h001, 1'b0, 1'b1, 1'b1);

    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) regs[($urandom % 15) + 1] = 16'($urandom);
      apply(4'($urandom), 4'($urandom), 12'($urandom), 1'($urandom % 4 == 0),
            1'($urandom), 1'($urandom % 4 != 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule